// File: doc/BRIEF.md
# Serial Link Request-to-Send Sequencer

This block decides when a synchronous serial transmitter may put a frame on the line. It uses the RTS/CTS modem handshake. A framer holds a frame-start request high while it has a frame queued. The sequencer raises RTS and checks CTS. It then grants a transmit enable and watches the frame until the framer reports completion or underrun, or until CTS falls. When a frame or the whole queue has to be thrown away, it tells the framer with one-cycle pulses. It also keeps saturating counters of aborts and of start failures.

Three link modes can be selected:
- Full-duplex point-to-point, where CTS must answer almost at once.
- Half-duplex, where the sequencer also stays off the line while the receiver is busy and shuts the receiver out while sending.
- Multipoint secondary, where RTS is raised and the sequencer waits for CTS up to a programmable limit.

The mode is captured only while the sequencer is idle.

Top module: `mdm_tx_seq`

## Requirements
- R1: After reset, rts_o, tx_en_o and every pulse output are low, rx_en_o is high and both counters are zero.
- R2: Mode encoding: 0 is full duplex, 1 is half duplex, 2 is multipoint, and 3 behaves as full duplex. In full duplex, a request seen while idle raises rts_o on the next cycle. CTS is sampled in each of the first two RTS cycles. If CTS is seen, tx_en_o rises on the following cycle.
- R3: In full or half duplex, if CTS is low in both sampled cycles, queue_flush_o pulses for one cycle and err_cnt_o increments in that same cycle. rts_o drops at the same time.
- R4: If CTS falls while sending and neither done nor underrun is reported, frame_drop_o and abort_o pulse together and abort_cnt_o increments. rts_o drops at the same time.
- R5: A transmit underrun while sending pulses frame_drop_o only. abort_o stays low and abort_cnt_o is unchanged.
- R6: rts_o stays high through the whole frame until tx_done_i. tx_done_i takes priority over underrun and CTS loss in the same cycle, and then nothing is dropped. tx_en_o is never high without rts_o.
- R7: In half duplex, while rx_busy_i is high, a pending request keeps rts_o low. Sending starts once rx_busy_i is low. While rts_o is high, rx_en_o is low.
- R8: In full duplex, a completion with the request still high keeps rts_o high and re-checks CTS for the next frame. In half duplex and multipoint, rts_o drops for at least one cycle after every completion.
- R9: In multipoint mode, rts_o stays high for at most cts_wait_lim_i+1 cycles while waiting for CTS. If CTS never comes, cts_timeout_o pulses, err_cnt_o increments, rts_o drops and queue_flush_o stays low.
- R10: mode_i is taken only while idle. A change made during a frame, including full-duplex back-to-back frames, has no effect until the sequencer next becomes idle.
- R11: Both counters saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Link mode select |
| start_req_i | input | 1 | Frame pending from framer (level) |
| cts_i | input | 1 | Clear to send from modem |
| rx_busy_i | input | 1 | Receiver active |
| tx_done_i | input | 1 | Framer finished current frame |
| tx_underrun_i | input | 1 | Framer ran out of data |
| cts_wait_lim_i | input | TMO_W | Multipoint CTS wait limit in cycles |
| rts_o | output | 1 | Request to send |
| tx_en_o | output | 1 | Transmit enable to framer |
| rx_en_o | output | 1 | Receiver enable |
| queue_flush_o | output | 1 | Discard all queued frames, write error |
| frame_drop_o | output | 1 | Discard current frame |
| abort_o | output | 1 | Send abort sequence on the line |
| cts_timeout_o | output | 1 | Multipoint CTS wait expired |
| abort_cnt_o | output | CNT_W | Abort counter |
| err_cnt_o | output | CNT_W | Start failure counter |

## Verification
The bench targets these corner cases:
- CTS that arrives on the second sampled cycle rather than the first. A design that samples only once would flush a good start.
- Completion that coincides with underrun or CTS loss. Getting the priority wrong drops a finished frame.
- Underrun versus CTS loss. Treating them alike either sends an abort on an underrun or leaves the abort count unchanged on a CTS loss.
- Back-to-back full-duplex frames, and a mode change during them. A design that releases RTS between frames, or that re-latches the mode mid-frame, departs from the reference model in the very cycle it does so.
- Half-duplex receive blocking, the multipoint timeout bound, and counter saturation.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic [1:0] {
    MODE_FDX = 2'd0,
    MODE_HDX = 2'd1,
    MODE_MPT = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RXWAIT  = 3'd1,
    ST_CHK     = 3'd2,
    ST_CTSWAIT = 3'd3,
    ST_SEND    = 3'd4
  } st_e;

  localparam int unsigned CHK_CYCLES = 2;
endpackage

// File: rtl/mdm_sat_cnt.sv
module mdm_sat_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_sat_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX) |=> (cnt_q == MAX));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q != MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mdm_fsm.sv
module mdm_fsm
  import mdm_pkg::*;
#(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             start_req_i,
  input  logic             cts_i,
  input  logic             rx_busy_i,
  input  logic             tx_done_i,
  input  logic             tx_underrun_i,
  input  logic [TMO_W-1:0] cts_lim_i,
  output logic             rts_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             flush_o,
  output logic             drop_o,
  output logic             abort_o,
  output logic             tmo_o,
  output logic             abort_inc_o,
  output logic             err_inc_o
);
  localparam logic [TMO_W-1:0] CHK_LAST = TMO_W'(CHK_CYCLES - 1);

  st_e              st_q, st_d;
  mode_e            mode_q, mode_in;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             flush_d, drop_d, abort_d, tmo_d;
  logic             flush_q, drop_q, abort_q, tmo_q;

  assign mode_in = (mode_i == 2'd3) ? MODE_FDX : mode_e'(mode_i);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    flush_d = 1'b0;
    drop_d  = 1'b0;
    abort_d = 1'b0;
    tmo_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_req_i) begin
          unique case (mode_in)
            MODE_HDX: st_d = rx_busy_i ? ST_RXWAIT : ST_CHK;
            MODE_MPT: st_d = ST_CTSWAIT;
            default:  st_d = ST_CHK;
          endcase
        end
      end
      ST_RXWAIT: begin
        if (!start_req_i)    st_d = ST_IDLE;
        else if (!rx_busy_i) st_d = ST_CHK;
      end
      ST_CHK: begin
        if (cts_i) st_d = ST_SEND;
        else if (cnt_q == CHK_LAST) begin
          st_d    = ST_IDLE;
          flush_d = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_CTSWAIT: begin
        if (cts_i) st_d = ST_SEND;
        else if (cnt_q == cts_lim_i) begin
          st_d  = ST_IDLE;
          tmo_d = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_SEND: begin
        if (tx_done_i) begin
          // full duplex holds RTS across back-to-back frames
          if (mode_q == MODE_FDX && start_req_i) begin
            st_d  = ST_CHK;
            cnt_d = '0;
          end else st_d = ST_IDLE;
        end else if (tx_underrun_i) begin
          st_d   = ST_IDLE;
          drop_d = 1'b1;
        end else if (!cts_i) begin
          st_d    = ST_IDLE;
          drop_d  = 1'b1;
          abort_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= MODE_FDX;
      cnt_q   <= '0;
      flush_q <= 1'b0;
      drop_q  <= 1'b0;
      abort_q <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      flush_q <= flush_d;
      drop_q  <= drop_d;
      abort_q <= abort_d;
      tmo_q   <= tmo_d;
      if (st_q == ST_IDLE) mode_q <= mode_in;
    end
  end

  assign rts_o       = (st_q == ST_CHK) || (st_q == ST_CTSWAIT) || (st_q == ST_SEND);
  assign tx_en_o     = (st_q == ST_SEND);
  assign rx_en_o     = !(mode_q == MODE_HDX && rts_o);
  assign flush_o     = flush_q;
  assign drop_o      = drop_q;
  assign abort_o     = abort_q;
  assign tmo_o       = tmo_q;
  assign abort_inc_o = abort_d;
  assign err_inc_o   = flush_d | tmo_d;

  p_cts_loss_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && !tx_done_i && !tx_underrun_i && !cts_i) |=> (abort_o && drop_o && !rts_o));
  p_underrun_silent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && !tx_done_i && tx_underrun_i) |=> (drop_o && !abort_o));
  p_done_no_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEND && tx_done_i) |=> !drop_o);
  p_hdx_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && mode_in == MODE_HDX && rx_busy_i) |=> !rts_o);
  p_mode_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(mode_q));
  p_flush_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
endmodule

// File: rtl/mdm_tx_seq.sv
module mdm_tx_seq #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             start_req_i,
  input  logic             cts_i,
  input  logic             rx_busy_i,
  input  logic             tx_done_i,
  input  logic             tx_underrun_i,
  input  logic [TMO_W-1:0] cts_wait_lim_i,
  output logic             rts_o,
  output logic             tx_en_o,
  output logic             rx_en_o,
  output logic             queue_flush_o,
  output logic             frame_drop_o,
  output logic             abort_o,
  output logic             cts_timeout_o,
  output logic [CNT_W-1:0] abort_cnt_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam int unsigned N_CNT = 2;

  logic             abort_inc, err_inc;
  logic [N_CNT-1:0] inc_vec;
  logic [CNT_W-1:0] cnt_vec [N_CNT];

  mdm_fsm #(.TMO_W(TMO_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .start_req_i  (start_req_i),
    .cts_i        (cts_i),
    .rx_busy_i    (rx_busy_i),
    .tx_done_i    (tx_done_i),
    .tx_underrun_i(tx_underrun_i),
    .cts_lim_i    (cts_wait_lim_i),
    .rts_o        (rts_o),
    .tx_en_o      (tx_en_o),
    .rx_en_o      (rx_en_o),
    .flush_o      (queue_flush_o),
    .drop_o       (frame_drop_o),
    .abort_o      (abort_o),
    .tmo_o        (cts_timeout_o),
    .abort_inc_o  (abort_inc),
    .err_inc_o    (err_inc)
  );

  assign inc_vec = {err_inc, abort_inc};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    mdm_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc_vec[g]),
      .cnt_o (cnt_vec[g])
    );
  end

  assign abort_cnt_o = cnt_vec[0];
  assign err_cnt_o   = cnt_vec[1];

  p_tx_en_rts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> rts_o);
  p_one_event_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({queue_flush_o, frame_drop_o, cts_timeout_o}));
  p_timeout_no_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_timeout_o |-> (!queue_flush_o && !rts_o));
endmodule

// File: tb/mdm_tx_seq_tb.sv
`timescale 1ns/1ps
module mdm_tx_seq_tb_top;
  localparam int CW = 4;
  localparam int TW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic req = 1'b0, cts = 1'b0, rxb = 1'b0, done = 1'b0, unr = 1'b0;
  logic [TW-1:0] lim = '0;
  logic rts, txen, rxen, flush, drop, abrt, tmo;
  logic [CW-1:0] acnt, ecnt;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mdm_tx_seq #(.CNT_W(CW), .TMO_W(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .start_req_i(req), .cts_i(cts),
    .rx_busy_i(rxb), .tx_done_i(done), .tx_underrun_i(unr), .cts_wait_lim_i(lim),
    .rts_o(rts), .tx_en_o(txen), .rx_en_o(rxen), .queue_flush_o(flush),
    .frame_drop_o(drop), .abort_o(abrt), .cts_timeout_o(tmo),
    .abort_cnt_o(acnt), .err_cnt_o(ecnt)
  );

  // behavioural reference: phase 0 idle, 1 rx wait, 2 cts check, 3 cts wait, 4 send
  int m_ph, m_mode, m_k, m_acnt, m_ecnt;
  bit m_flush, m_drop, m_abort, m_tmo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_mode = 0; m_k = 0; m_acnt = 0; m_ecnt = 0;
      m_flush = 0; m_drop = 0; m_abort = 0; m_tmo = 0;
    end else begin
      m_flush = 0; m_drop = 0; m_abort = 0; m_tmo = 0;
      case (m_ph)
        0: begin
          m_mode = (mode == 3) ? 0 : int'(mode);
          m_k = 0;
          if (req) begin
            if (m_mode == 1) m_ph = rxb ? 1 : 2;
            else if (m_mode == 2) m_ph = 3;
            else m_ph = 2;
          end
        end
        1: if (!req) m_ph = 0; else if (!rxb) m_ph = 2;
        2: if (cts) m_ph = 4;
           else if (m_k == 1) begin m_ph = 0; m_flush = 1; end
           else m_k++;
        3: if (cts) m_ph = 4;
           else if (m_k == int'(lim)) begin m_ph = 0; m_tmo = 1; end
           else m_k++;
        4: if (done) begin
             if (m_mode == 0 && req) begin m_ph = 2; m_k = 0; end
             else m_ph = 0;
           end else if (unr) begin m_ph = 0; m_drop = 1; end
           else if (!cts) begin m_ph = 0; m_drop = 1; m_abort = 1; end
        default: m_ph = 0;
      endcase
      if ((m_flush || m_tmo) && m_ecnt < CMAX) m_ecnt++;
      if (m_abort && m_acnt < CMAX) m_acnt++;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit e_rts = (m_ph >= 2);
      cmp("R6 rts_o", rts, e_rts);
      cmp("R2 tx_en_o", txen, m_ph == 4);
      cmp("R7 rx_en_o", rxen, !(m_mode == 1 && e_rts));
      cmp("R3 queue_flush_o", flush, m_flush);
      cmp("R5 frame_drop_o", drop, m_drop);
      cmp("R4 abort_o", abrt, m_abort);
      cmp("R9 cts_timeout_o", tmo, m_tmo);
      cmp("R4 abort_cnt_o", acnt, m_acnt);
      cmp("R11 err_cnt_o", ecnt, m_ecnt);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // bring the sequencer to sending in full duplex with CTS up
  task automatic fdx_start();
    mode = 2'd0; cts = 1; req = 1;
    tick(); req = 0;
    tick();
  endtask

  task automatic finish_frame();
    done = 1; tick(); done = 0; tick();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    cmp("R1 rts_o reset", rts, 0);
    cmp("R1 tx_en_o reset", txen, 0);
    cmp("R1 rx_en_o reset", rxen, 1);
    cmp("R1 pulses reset", {flush, drop, abrt, tmo}, 0);
    cmp("R1 counters reset", {acnt, ecnt}, 0);
    rst_n = 1;
    tick(2);

    // R2 CTS present at once
    mode = 2'd0; cts = 1; req = 1;
    tick(); cmp("R2 rts after request", rts, 1); cmp("R2 tx_en not yet", txen, 0);
    req = 0;
    tick(); cmp("R2 tx_en after cts", txen, 1);
    tick(3); cmp("R6 rts held mid-frame", rts, 1);
    finish_frame(); cmp("R6 rts released after done", rts, 0);

    // R2 CTS on second sampled cycle
    cts = 0; req = 1;
    tick(); req = 0;
    tick(); cts = 1;
    tick(); cmp("R2 late cts accepted", txen, 1);
    cmp("R2 no flush on late cts", ecnt, 0);
    finish_frame();

    // R3 CTS absent
    cts = 0; req = 1;
    tick(); req = 0;
    tick(); cmp("R3 rts during second check", rts, 1);
    tick(); cmp("R3 flush pulse", flush, 1); cmp("R3 err_cnt", ecnt, 1); cmp("R3 rts dropped", rts, 0);
    tick(); cmp("R3 flush one cycle", flush, 0);

    // R4 CTS loss mid-frame
    fdx_start(); cts = 0;
    tick(); cmp("R4 drop", drop, 1); cmp("R4 abort", abrt, 1); cmp("R4 abort_cnt", acnt, 1); cmp("R4 rts", rts, 0);
    tick();

    // R5 underrun
    fdx_start(); unr = 1;
    tick(); unr = 0;
    cmp("R5 drop", drop, 1); cmp("R5 no abort", abrt, 0); cmp("R5 abort_cnt kept", acnt, 1);
    tick();

    // R6 done wins over underrun and cts loss
    fdx_start(); done = 1; unr = 1; cts = 0;
    tick(); done = 0; unr = 0;
    cmp("R6 done priority no drop", drop, 0); cmp("R6 done priority no abort", acnt, 1);
    tick();

    // R8 full-duplex back-to-back, R10 mode change ignored mid-frame
    fdx_start(); mode = 2'd1; done = 1; req = 1;
    tick(); done = 0;
    cmp("R8 rts held between frames", rts, 1); cmp("R8 recheck cts", txen, 0);
    tick(); cmp("R8 second frame sending", txen, 1); cmp("R10 rx_en still open", rxen, 1);
    done = 1;
    tick(); done = 0;
    cmp("R10 back-to-back kept in latched mode", rts, 1);
    req = 0;
    tick(); finish_frame();
    cmp("R10 idle after frames", rts, 0);

    // R7 half duplex receiver blocking
    mode = 2'd1; rxb = 1; req = 1; cts = 1;
    tick(); cmp("R7 rts held off by rx busy", rts, 0);
    tick(); cmp("R7 rts still off", rts, 0);
    rxb = 0;
    tick(); cmp("R7 rts after rx idle", rts, 1); cmp("R7 rx_en closed", rxen, 0);
    tick(); cmp("R7 sending", txen, 1);
    rxb = 1;
    tick(); cmp("R7 rx_en closed while sending", rxen, 0);
    done = 1;
    tick(); done = 0;
    cmp("R8 hdx rts drops despite request", rts, 0);
    req = 0;
    tick(2); rxb = 0;

    // R3 half duplex missing CTS
    cts = 0; req = 1;
    tick(); req = 0;
    tick(2); cmp("R3 hdx flush", flush, 1);
    tick();

    // R9 multipoint wait then grant
    mode = 2'd2; lim = 4'd3; cts = 0; req = 1;
    tick(); req = 0; cmp("R9 rts raised", rts, 1);
    tick(2); cts = 1;
    tick(); cmp("R9 granted after wait", txen, 1);
    finish_frame(); cmp("R8 mpt rts dropped", rts, 0);

    // R9 multipoint timeout
    lim = 4'd2; cts = 0; req = 1;
    tick(); req = 0;
    tick(2); cmp("R9 rts at limit", rts, 1);
    tick(); cmp("R9 timeout pulse", tmo, 1); cmp("R9 no flush", flush, 0);
    cmp("R9 rts off", rts, 0); cmp("R9 err_cnt", ecnt, 3);
    tick();

    // R11 saturation, mode 3 acts as full duplex
    mode = 2'd3; cts = 0;
    for (int i = 0; i < 16; i++) begin
      req = 1; tick(); req = 0; tick(3);
    end
    cmp("R11 err_cnt saturated", ecnt, CMAX);
    tick(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule